// File: doc/BRIEF.md
# Byte alignment and shuffle unit

This block rearranges the bytes of a packed vector in one of two ways. In align mode it places operand A above operand B to form a value twice the vector width. It shifts that value right by a whole number of bytes, which is given as an immediate count, and the low half of the shifted value is the answer. In shuffle mode each output byte is picked from operand A by the control byte in the same lane. A control byte can also force its output byte to zero.

The same datapath serves 128-bit vectors (16 lanes) and 64-bit vectors (8 lanes), chosen per operation by a width input. A request is taken on any cycle that has the input valid high. The result appears on a register one clock later, together with an output valid. Between requests the result register keeps its last value.

Top module: `bperm_unit`

## Requirements
- R1: While reset is asserted, `out_valid_o` is 0 and `res_o` is all zeros.
- R2: `out_valid_o` is high in exactly the cycles that follow a cycle with `in_valid_i` high. The result of that request is on `res_o` in that same cycle.
- R3: After a cycle with `in_valid_i` low, `res_o` keeps its previous value, whatever the other inputs do.
- R4: With `mode_i`=0 (align) and `wide_i`=1 (128-bit), `res_o` is the low 128 bits of the 256-bit value {src_a_i, src_b_i} shifted right by 8×`shamt_i` bits, for `shamt_i` below 32.
- R5: With `mode_i`=0 and `wide_i`=0 (64-bit), bytes 7..0 of `res_o` are the low 64 bits of {src_a_i[63:0], src_b_i[63:0]} shifted right by 8×`shamt_i` bits. Bytes 15..8 of `res_o` are zero, and bits 127..64 of both operands have no effect.
- R6: In align mode, a `shamt_i` of 32 or more (128-bit) or 16 or more (64-bit) gives an all-zero result.
- R7: With `mode_i`=1 (shuffle), every output lane whose control byte has bit 7 set is zero.
- R8: In 128-bit shuffle with bit 7 clear, output byte j equals the byte of `src_a_i` whose lane number is given by bits [3:0] of control byte j (`ctl_i[8j+7:8j]`).
- R9: Control bits [6:4] have no effect on the shuffle result.
- R10: In 64-bit shuffle, bits [2:0] of the control byte select one of bytes 7..0 of `src_a_i`, and bit 3 is ignored. Output bytes 15..8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = align, 1 = shuffle |
| wide_i | input | 1 | 1 = 128-bit vectors, 0 = 64-bit vectors |
| src_a_i | input | 128 | Upper align operand, shuffle data source |
| src_b_i | input | 128 | Lower align operand |
| ctl_i | input | 128 | Shuffle control bytes, one per lane |
| shamt_i | input | 8 | Align byte shift count |
| res_o | output | 128 | Registered result |
| out_valid_o | output | 1 | Result valid, one cycle after the request |

## Verification
The bench builds the unit with its default parameters: 16 lanes at most, 8 lanes in the narrow width, and an 8-bit shift count. Because the count is 8 bits wide, values far beyond the 32-byte concatenation, up to 255, can be driven. This exercises the all-zero boundary in both widths at, just below, and far past its edge. The 8-lane narrow width sits inside the 16-lane datapath, which lets the bench put noise in the unused upper operand bytes and in control bit 3 and check that none of it leaks into the result.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  typedef enum logic {
    OP_ALIGN   = 1'b0,
    OP_SHUFFLE = 1'b1
  } bperm_op_e;
endpackage

// File: rtl/bperm_align.sv
// Concatenate-and-window extractor: hi above lo, shifted right by whole bytes.
module bperm_align #(
  parameter int LANES  = 16,
  parameter int NARROW = 8,
  parameter int CNT_W  = 8
) (
  input  logic [8*LANES-1:0] hi_i,
  input  logic [8*LANES-1:0] lo_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               wide_i,
  output logic [8*LANES-1:0] win_o
);
  localparam int CAT    = 2 * LANES;
  localparam int CAT_IW = $clog2(CAT);

  logic [7:0] cat_b [CAT];

  // Double-width byte array; in narrow mode only 2*NARROW bytes are populated.
  always_comb begin
    for (int k = 0; k < CAT; k++) begin
      cat_b[k] = '0;
      if (wide_i) begin
        if (k < LANES) cat_b[k] = lo_i[8*k +: 8];
        else           cat_b[k] = hi_i[8*(k-LANES) +: 8];
      end else begin
        if (k < NARROW)        cat_b[k] = lo_i[8*k +: 8];
        else if (k < 2*NARROW) cat_b[k] = hi_i[8*(k-NARROW) +: 8];
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [CNT_W:0] pos;
    logic           active;
    always_comb begin
      pos    = (CNT_W+1)'(j) + {1'b0, cnt_i};
      active = wide_i || (j < NARROW);
      if (active && (pos < (CNT_W+1)'(CAT)))
        win_o[8*j +: 8] = cat_b[pos[CAT_IW-1:0]];
      else
        win_o[8*j +: 8] = '0;
    end
  end
endmodule

// File: rtl/bperm_shuffle.sv
// Per-lane byte selector driven by control bytes; bit 7 zeroes the lane.
module bperm_shuffle #(
  parameter int LANES  = 16,
  parameter int NARROW = 8
) (
  input  logic [8*LANES-1:0] src_i,
  input  logic [8*LANES-1:0] ctl_i,
  input  logic               wide_i,
  output logic [8*LANES-1:0] out_o
);
  localparam int IDX_W  = $clog2(LANES);
  localparam int NIDX_W = $clog2(NARROW);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0]       cbyte;
    logic [IDX_W-1:0] sel;
    logic             active;
    always_comb begin
      cbyte  = ctl_i[8*j +: 8];
      active = wide_i || (j < NARROW);
      if (wide_i) sel = cbyte[IDX_W-1:0];
      else        sel = IDX_W'(cbyte[NIDX_W-1:0]);
      if (!active || cbyte[7]) out_o[8*j +: 8] = '0;
      else                     out_o[8*j +: 8] = src_i[8*sel +: 8];
    end
  end
endmodule

// File: rtl/bperm_outreg.sv
// Result register with explicit clock enable and a one-cycle valid.
module bperm_outreg #(
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  always_comb begin
    res_d = res_q;
    if (en_i) res_d = d_i;
    vld_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign q_o   = res_q;
  assign vld_o = vld_q;

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> vld_o);
  p_no_spurious_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !vld_o);
  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit #(
  parameter int LANES  = 16,
  parameter int NARROW = 8,
  parameter int CNT_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 mode_i,
  input  logic                 wide_i,
  input  logic [8*LANES-1:0]   src_a_i,
  input  logic [8*LANES-1:0]   src_b_i,
  input  logic [8*LANES-1:0]   ctl_i,
  input  logic [CNT_W-1:0]     shamt_i,
  output logic [8*LANES-1:0]   res_o,
  output logic                 out_valid_o
);
  import bperm_pkg::*;

  localparam int DATA_W   = 8 * LANES;
  localparam int NDATA_W  = 8 * NARROW;
  localparam int WIDE_LIM = 2 * LANES;
  localparam int NARR_LIM = 2 * NARROW;

  bperm_op_e         op;
  logic [DATA_W-1:0] align_res, shuf_res, sel_res;

  assign op = bperm_op_e'(mode_i);

  bperm_align #(.LANES(LANES), .NARROW(NARROW), .CNT_W(CNT_W)) u_align (
    .hi_i  (src_a_i),
    .lo_i  (src_b_i),
    .cnt_i (shamt_i),
    .wide_i(wide_i),
    .win_o (align_res)
  );

  bperm_shuffle #(.LANES(LANES), .NARROW(NARROW)) u_shuffle (
    .src_i (src_a_i),
    .ctl_i (ctl_i),
    .wide_i(wide_i),
    .out_o (shuf_res)
  );

  always_comb begin
    case (op)
      OP_SHUFFLE: sel_res = shuf_res;
      default:    sel_res = align_res;
    endcase
  end

  bperm_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (in_valid_i),
    .d_i   (sel_res),
    .q_o   (res_o),
    .vld_o (out_valid_o)
  );

  p_narrow_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !wide_i) |=> (res_o[DATA_W-1:NDATA_W] == '0));

  p_align_overrun_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (mode_i == 1'b0) &&
     (({1'b0, shamt_i} >= (CNT_W+1)'(WIDE_LIM)) ||
      (!wide_i && ({1'b0, shamt_i} >= (CNT_W+1)'(NARR_LIM)))))
    |=> (res_o == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_zero_chk
    p_ctl_clear_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && (mode_i == 1'b1) && ctl_i[8*j+7]) |=> (res_o[8*j +: 8] == 8'h00));
  end
endmodule

// File: tb/bperm_unit_test.sv
`timescale 1ns/1ps
module bperm_unit_test;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         in_valid_i, mode_i, wide_i;
  logic [127:0] src_a_i, src_b_i, ctl_i;
  logic [7:0]   shamt_i;
  logic [127:0] res_o;
  logic         out_valid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  int           cyc_q [$];
  logic [127:0] last_res;
  bit           run_mon = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bperm_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .wide_i(wide_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .ctl_i(ctl_i),
    .shamt_i(shamt_i), .res_o(res_o), .out_valid_o(out_valid_o)
  );

  function automatic logic [127:0] model(bit m, bit w, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] c,
                                         logic [7:0] n);
    logic [255:0] cat;
    logic [127:0] r;
    r = '0;
    if (!m) begin
      if (w) cat = {a, b};
      else   cat = {128'h0, a[63:0], b[63:0]};
      if (int'(n) < 32) cat = cat >> (8 * int'(n));
      else cat = '0;
      r = w ? cat[127:0] : {64'h0, cat[63:0]};
    end else begin
      for (int j = 0; j < (w ? 16 : 8); j++) begin
        logic [7:0] cb;
        cb = c[8*j +: 8];
        if (!cb[7]) r[8*j +: 8] = w ? a[8*cb[3:0] +: 8] : a[8*cb[2:0] +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic op(bit m, bit w, logic [127:0] a, logic [127:0] b,
                    logic [127:0] c, logic [7:0] n, string tag);
    @(negedge clk);
    in_valid_i = 1'b1; mode_i = m; wide_i = w;
    src_a_i = a; src_b_i = b; ctl_i = c; shamt_i = n;
    exp_q.push_back(model(m, w, a, b, c, n));
    tag_q.push_back(tag);
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid_i = 1'b0; mode_i = $urandom; wide_i = $urandom;
      src_a_i = rnd128(); src_b_i = rnd128(); ctl_i = rnd128(); shamt_i = $urandom;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (run_mon) begin
        bit exp_v;
        exp_v = (cyc_q.size() > 0) && (cyc_q[0] == cyc - 1);
        checks++;
        if (out_valid_o !== exp_v) begin
          fails++;
          $display("FAIL R2: out_valid actual %0b expected %0b", out_valid_o, exp_v);
        end
        if (exp_v) begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front(); void'(cyc_q.pop_front());
          checks++;
          if (res_o !== e) begin
            fails++;
            $display("FAIL %s: result actual %h expected %h", t, res_o, e);
          end
          last_res = e;
        end else begin
          checks++;
          if (res_o !== last_res) begin
            fails++;
            $display("FAIL R3: held result actual %h expected %h", res_o, last_res);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [127:0] A0 = 128'hAF_AE_AD_AC_AB_AA_A9_A8_A7_A6_A5_A4_A3_A2_A1_A0;
  localparam logic [127:0] B0 = 128'hBF_BE_BD_BC_BB_BA_B9_B8_B7_B6_B5_B4_B3_B2_B1_B0;

  initial begin
    logic [127:0] rev, ident, mixed;
    rst_ni = 1'b0; in_valid_i = 1'b0; mode_i = 1'b0; wide_i = 1'b1;
    src_a_i = '0; src_b_i = '0; ctl_i = '0; shamt_i = '0;
    last_res = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || res_o !== '0) begin
      fails++;
      $display("FAIL R1: reset state actual %b/%h expected 0/0", out_valid_o, res_o);
    end
    rst_ni = 1'b1;
    run_mon = 1'b1;
    idle(2);

    for (int j = 0; j < 16; j++) begin
      rev[8*j +: 8]   = 8'(15 - j);
      ident[8*j +: 8] = 8'(j);
      mixed[8*j +: 8] = (j % 3 == 0) ? 8'h80 : 8'(j ^ 5);
    end

    // R4: wide align, back-to-back stream also covers R2
    op(0, 1, A0, B0, '0, 8'd0,  "R4");
    op(0, 1, A0, B0, '0, 8'd5,  "R4");
    op(0, 1, A0, B0, '0, 8'd16, "R4");
    op(0, 1, A0, B0, '0, 8'd31, "R4");
    idle(3);
    // R6: overrun boundaries
    op(0, 1, A0, B0, '0, 8'd32,  "R6");
    op(0, 1, A0, B0, '0, 8'd255, "R6");
    op(0, 0, A0, B0, '0, 8'd16,  "R6");
    op(0, 0, A0, B0, '0, 8'd15,  "R5");
    // R5: narrow align with noise in upper operand halves
    op(0, 0, A0, B0, '0, 8'd3, "R5");
    op(0, 0, {64'hDEAD_BEEF_0123_4567, A0[63:0]}, {64'hFFFF_0000_FFFF_0000, B0[63:0]}, '0, 8'd3, "R5");
    idle(2);
    // R8: wide shuffle
    op(1, 1, A0, B0, rev, 8'd0, "R8");
    op(1, 1, A0, B0, ident, 8'd0, "R8");
    // R7: zeroed lanes
    op(1, 1, A0, B0, mixed, 8'd0, "R7");
    op(1, 1, A0, B0, {16{8'h8F}}, 8'd0, "R7");
    // R9: reserved bits set should match the reversed result
    op(1, 1, A0, B0, rev | {16{8'h70}}, 8'd0, "R9");
    // R10: narrow shuffle, bit 3 and reserved bits set
    op(1, 0, A0, B0, rev | {16{8'h08}}, 8'd0, "R10");
    op(1, 0, A0, B0, mixed | {16{8'h38}}, 8'd0, "R10");
    idle(4);
    // Random mix with gaps (R3 checked on idle cycles)
    for (int i = 0; i < 200; i++) begin
      op($urandom, $urandom, rnd128(), rnd128(), rnd128(), 8'($urandom % 40), "R4/R5/R8/R10 random");
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end
    idle(4);
    run_mon = 1'b0;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: pending results actual %0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule